// File: doc/BRIEF.md
# Slave-SPI Configuration Loader

This block brings up a small companion FPGA through that device's slave-SPI configuration port. After a start pulse it drives the target's reset and chip select in the order that forces slave configuration mode, waits out the target's internal start-up time, clocks one dummy byte with the chip deasserted, and then streams a fixed-size bitstream image to the target. The image arrives as whole pages from a byte-stream source, standing in for a flash reader, through a page-request strobe and a valid/ready byte handshake.

The first bytes of the image must carry a fixed signature. While the image is sent the block compares those bytes against the signature. When the image is complete it releases chip select, gives the target the trailing dummy clocks it needs before configuration-done can be trusted, and samples that input. If the target reports done, a further run of dummy clocks follows. The outcome is a 2-bit result code. The code is held, together with a done flag, until the next start. A stalled or failing source aborts the sequence. All delays and sizes are parameters counted in system-clock cycles or bytes.

Top module: `slvcfg_loader`

## Requirements
- R1: The SPI runs in mode 3. `tgt_sck` idles high and each bit spends CLK_DIV/2 system cycles low, then CLK_DIV/2 high. `tgt_mosi` changes only when `tgt_sck` falls. Bytes go out most significant bit first. `tgt_cs_n` changes only while `tgt_sck` is high.
- R2: After reset, `tgt_rst_n`=0, `tgt_cs_n`=1, `tgt_sck`=1, `busy`=0, `done`=0 and `result`=0.
- R3: On `start`, the block drives `tgt_cs_n` low and holds `tgt_rst_n` low for at least RST_HOLD_CYC cycles with the chip selected. It then releases `tgt_rst_n` while `tgt_cs_n` is still low.
- R4: After the reset release, no `tgt_sck` edge occurs for at least WAKE_CYC cycles. Then `tgt_cs_n` goes high for exactly PRE_BYTES×8 rising clocks, and returns low before the image is sent.
- R5: The image is NUM_PAGES pages of PAGE_BYTES bytes. For each page the block pulses `src_page_req` with `src_page` counting up from 0, then accepts bytes while `src_valid` and `src_ready` are both high. It forwards every byte unchanged, in order, with `tgt_cs_n` low.
- R6: The first MARKER_LEN bytes of page 0 are compared with MARKER, whose most significant byte is expected first. On any mismatch the whole image is still sent, no trailing clocks follow, and `result` is 2.
- R7: After a matching image, `tgt_cs_n` goes high and TAIL_BYTES×8 rising clocks are sent. Then `tgt_done` is sampled through a two-stage synchronizer. If it is low, `result` is 3 and no further clocks follow.
- R8: If the sampled done is high, POST_BYTES×8 more rising clocks are sent and `result` is 0.
- R9: The sequence aborts, with `tgt_cs_n` high and no further clocks, in two cases: the source holds `src_valid` low for TIMEOUT_CYC cycles while a byte is awaited, or `src_err` is high while a byte is awaited. `result` is then 1, or 2 if a marker mismatch was already seen.
- R10: `busy` is high from the cycle after `start` until completion. `done` then stays high and `result` stays stable until the next start. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration sequence (ignored while busy) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; result valid |
| result | output | 2 | 0 ok, 1 transfer/source failure, 2 signature mismatch, 3 target not configured |
| src_page_req | output | 1 | One-cycle request for the next page |
| src_page | output | PG_W | Index of the requested page |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_err | input | 1 | Source read failure |
| src_ready | output | 1 | Block is waiting for a byte |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target chip select, active low |
| tgt_sck | output | 1 | SPI clock |
| tgt_mosi | output | 1 | SPI data to target |
| tgt_done | input | 1 | Target configuration-done, asynchronous |

## Verification
The sequencer state shows up directly at the target pins. A wrong step order therefore appears as a reset released with the chip deselected, as clocks inside the wake window, or as a wrong count of deselected clocks before or after the image. Each of these becomes visible within one byte time of the faulty transition. A broken byte or page counter changes the number of page requests and the byte stream the target captures. A broken signature or timeout path changes the held result code at the end of the run. The bench reconstructs every captured byte and every deselected clock edge, and compares them with counts derived from the parameters.

// File: rtl/slvcfg_pkg.sv
package slvcfg_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_XFER   = 2'd1,
        RES_NOIMG  = 2'd2,
        RES_NODONE = 2'd3
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAKE,
        ST_PRE,
        ST_PAGE,
        ST_WAIT,
        ST_SEND,
        ST_TAIL,
        ST_SAMPLE,
        ST_POST
    } st_e;

    localparam byte_t DUMMY_BYTE = 8'hFF;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // bits needed to index n distinct values
    function automatic int cw(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/slvcfg_timer.sv
module slvcfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    assert_count_down_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/slvcfg_shifter.sv
module slvcfg_shifter
    import slvcfg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  byte_t data,
    output logic  idle,
    output logic  fin,
    output logic  sck,
    output logic  mosi
);
    localparam int HALF = CLK_DIV / 2;
    localparam int HW   = cw(HALF);
    localparam logic [HW-1:0] HALF_END = HW'(HALF - 1);

    logic          active_q;
    byte_t         sr_q;
    logic [2:0]    bit_q;
    logic [HW-1:0] hcnt_q;
    logic          sck_q;
    logic          mosi_q;
    logic          fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sr_q     <= '0;
            bit_q    <= '0;
            hcnt_q   <= '0;
            sck_q    <= 1'b1;
            mosi_q   <= 1'b1;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    sr_q     <= data;
                    mosi_q   <= data[7];
                    sck_q    <= 1'b0;
                    bit_q    <= '0;
                    hcnt_q   <= '0;
                end
            end else if (hcnt_q == HALF_END) begin
                hcnt_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else if (bit_q == 3'd7) begin
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end else begin
                    bit_q  <= bit_q + 1'b1;
                    sr_q   <= {sr_q[6:0], 1'b0};
                    mosi_q <= sr_q[6];
                    sck_q  <= 1'b0;
                end
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    assign idle = !active_q;
    assign fin  = fin_q;
    assign sck  = sck_q;
    assign mosi = mosi_q;

    assert_mosi_hold_high_R1: assert property (@(posedge clk) disable iff (rst)
        (sck_q && $past(sck_q)) |-> $stable(mosi_q));

    assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !$past(active_q)) |-> sck_q);

endmodule

// File: rtl/slvcfg_marker.sv
module slvcfg_marker
    import slvcfg_pkg::*;
#(
    parameter int MARKER_LEN = 4,
    parameter logic [8*MARKER_LEN-1:0] MARKER = '0,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          chk,
    input  logic [IW-1:0] idx,
    input  byte_t         data,
    output logic          bad
);
    logic  bad_q;
    byte_t expect_b;

    always_comb begin
        expect_b = '0;
        for (int k = 0; k < MARKER_LEN; k++) begin
            if (int'(idx) == k) expect_b = MARKER[(MARKER_LEN-1-k)*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bad_q <= 1'b0;
        end else if (chk && (data != expect_b)) begin
            bad_q <= 1'b1;
        end
    end

    assign bad = bad_q;

    assert_bad_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(bad_q) && !$past(clr)) |-> bad_q);

endmodule

// File: rtl/slvcfg_loader.sv
module slvcfg_loader
    import slvcfg_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int RST_HOLD_CYC = 90,
    parameter int WAKE_CYC     = 180000,
    parameter int PAGE_BYTES   = 256,
    parameter int NUM_PAGES    = 512,
    parameter int MARKER_LEN   = 4,
    parameter logic [8*MARKER_LEN-1:0] MARKER = 32'h7EAA997E,
    parameter int TIMEOUT_CYC  = 1000,
    parameter int PRE_BYTES    = 1,
    parameter int TAIL_BYTES   = 16,
    parameter int POST_BYTES   = 8,
    localparam int PG_W        = cw(NUM_PAGES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic [1:0]      result,
    output logic            src_page_req,
    output logic [PG_W-1:0] src_page,
    input  logic            src_valid,
    input  logic [7:0]      src_data,
    input  logic            src_err,
    output logic            src_ready,
    output logic            tgt_rst_n,
    output logic            tgt_cs_n,
    output logic            tgt_sck,
    output logic            tgt_mosi,
    input  logic            tgt_done
);
    localparam int BY_W  = cw(PAGE_BYTES);
    localparam int TMR_W = cw(max3(RST_HOLD_CYC, WAKE_CYC, TIMEOUT_CYC) + 1);
    localparam int DMY_W = cw(max3(PRE_BYTES, TAIL_BYTES, POST_BYTES) + 1);
    localparam logic [PG_W-1:0] LAST_PG = PG_W'(NUM_PAGES - 1);
    localparam logic [BY_W-1:0] LAST_BY = BY_W'(PAGE_BYTES - 1);

    st_e              st_q;
    logic             cs_n_q, rst_n_q, done_q;
    res_e             res_q;
    logic [PG_W-1:0]  pg_q;
    logic [BY_W-1:0]  by_q;
    logic [DMY_W-1:0] dmy_q;
    logic [1:0]       dsync_q;

    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             sh_go, sh_idle, sh_fin, sh_sck, sh_mosi;
    byte_t            sh_byte;
    logic             mk_clr, mk_chk, mk_bad;
    logic             in_dummy, dmy_last, take_byte, accept_start;

    assign accept_start = (st_q == ST_IDLE) && start;
    assign in_dummy     = (st_q == ST_PRE) || (st_q == ST_TAIL) || (st_q == ST_POST);
    assign dmy_last     = (dmy_q == DMY_W'(1));
    assign take_byte    = (st_q == ST_WAIT) && src_valid && !src_err;

    // control of the shared delay timer
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept_start) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(RST_HOLD_CYC);
        end else if (st_q == ST_HOLD && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(WAKE_CYC);
        end else if (st_q == ST_PAGE ||
                     (st_q == ST_SEND && sh_fin && by_q != LAST_BY)) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TIMEOUT_CYC);
        end
    end

    assign sh_go   = (in_dummy && sh_idle && !(sh_fin && dmy_last)) || take_byte;
    assign sh_byte = (st_q == ST_WAIT) ? src_data : DUMMY_BYTE;
    assign mk_clr  = accept_start;
    assign mk_chk  = take_byte && (pg_q == '0) && (int'(by_q) < MARKER_LEN);

    slvcfg_timer #(.W(TMR_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    slvcfg_shifter #(.CLK_DIV(CLK_DIV)) u_shifter (
        .clk  (clk),
        .rst  (rst),
        .go   (sh_go),
        .data (sh_byte),
        .idle (sh_idle),
        .fin  (sh_fin),
        .sck  (sh_sck),
        .mosi (sh_mosi)
    );

    slvcfg_marker #(.MARKER_LEN(MARKER_LEN), .MARKER(MARKER), .IW(BY_W)) u_marker (
        .clk  (clk),
        .rst  (rst),
        .clr  (mk_clr),
        .chk  (mk_chk),
        .idx  (by_q),
        .data (src_data),
        .bad  (mk_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dsync_q <= '0;
        end else begin
            dsync_q <= {dsync_q[0], tgt_done};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cs_n_q  <= 1'b1;
            rst_n_q <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= RES_OK;
            pg_q    <= '0;
            by_q    <= '0;
            dmy_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        cs_n_q  <= 1'b0;
                        rst_n_q <= 1'b0;
                        done_q  <= 1'b0;
                        res_q   <= RES_OK;
                        st_q    <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (tmr_zero) begin
                        rst_n_q <= 1'b1;
                        st_q    <= ST_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (tmr_zero) begin
                        cs_n_q <= 1'b1;
                        dmy_q  <= DMY_W'(PRE_BYTES);
                        st_q   <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (sh_fin) begin
                        dmy_q <= dmy_q - 1'b1;
                        if (dmy_last) begin
                            cs_n_q <= 1'b0;
                            pg_q   <= '0;
                            st_q   <= ST_PAGE;
                        end
                    end
                end
                ST_PAGE: begin
                    by_q <= '0;
                    st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (src_err || (!src_valid && tmr_zero)) begin
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        res_q  <= mk_bad ? RES_NOIMG : RES_XFER;
                        st_q   <= ST_IDLE;
                    end else if (src_valid) begin
                        st_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (sh_fin) begin
                        if (by_q != LAST_BY) begin
                            by_q <= by_q + 1'b1;
                            st_q <= ST_WAIT;
                        end else if (pg_q != LAST_PG) begin
                            pg_q <= pg_q + 1'b1;
                            st_q <= ST_PAGE;
                        end else begin
                            cs_n_q <= 1'b1;
                            if (mk_bad) begin
                                done_q <= 1'b1;
                                res_q  <= RES_NOIMG;
                                st_q   <= ST_IDLE;
                            end else begin
                                dmy_q <= DMY_W'(TAIL_BYTES);
                                st_q  <= ST_TAIL;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    if (sh_fin) begin
                        dmy_q <= dmy_q - 1'b1;
                        if (dmy_last) st_q <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    if (dsync_q[1]) begin
                        dmy_q <= DMY_W'(POST_BYTES);
                        st_q  <= ST_POST;
                    end else begin
                        done_q <= 1'b1;
                        res_q  <= RES_NODONE;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_POST: begin
                    if (sh_fin) begin
                        dmy_q <= dmy_q - 1'b1;
                        if (dmy_last) begin
                            done_q <= 1'b1;
                            res_q  <= RES_OK;
                            st_q   <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (st_q != ST_IDLE);
    assign done         = done_q;
    assign result       = res_q;
    assign src_page_req = (st_q == ST_PAGE);
    assign src_page     = pg_q;
    assign src_ready    = (st_q == ST_WAIT);
    assign tgt_rst_n    = rst_n_q;
    assign tgt_cs_n     = cs_n_q;
    assign tgt_sck      = sh_sck;
    assign tgt_mosi     = sh_mosi;

    assert_cs_moves_clock_high_R1: assert property (@(posedge clk) disable iff (rst)
        (cs_n_q != $past(cs_n_q)) |-> (sh_sck && $past(sh_sck)));

    assert_release_while_selected_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_q) |-> !cs_n_q);

    assert_no_clock_in_reset_R4: assert property (@(posedge clk) disable iff (rst)
        !rst_n_q |-> sh_sck);

    assert_ready_only_when_selected_R5: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> (!cs_n_q && rst_n_q));

    assert_finish_raises_done_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_q);

    assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
        (done_q && $past(done_q)) |-> $stable(res_q));

endmodule

// File: tb/slvcfg_loader_bench.sv
module slvcfg_loader_bench;
    import slvcfg_pkg::*;

    localparam int CLK_DIV = 4;
    localparam int RHOLD   = 5;
    localparam int WAKE    = 20;
    localparam int PB      = 4;
    localparam int NP      = 3;
    localparam int ML      = 2;
    localparam int TMO     = 30;
    localparam int TAILB   = 16;
    localparam int POSTB   = 8;
    localparam logic [15:0] MK = 16'hC35A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       busy, done;
    logic [1:0] result;
    logic       src_page_req;
    logic [1:0] src_page;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_err = 1'b0;
    logic       src_ready;
    logic       tgt_rst_n, tgt_cs_n, tgt_sck, tgt_mosi;
    logic       tgt_done = 1'b0;

    always #4 clk = ~clk;

    slvcfg_loader #(
        .CLK_DIV(CLK_DIV), .RST_HOLD_CYC(RHOLD), .WAKE_CYC(WAKE),
        .PAGE_BYTES(PB), .NUM_PAGES(NP), .MARKER_LEN(ML), .MARKER(MK),
        .TIMEOUT_CYC(TMO), .PRE_BYTES(1), .TAIL_BYTES(TAILB), .POST_BYTES(POSTB)
    ) u_slvcfg_loader (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .result(result), .src_page_req(src_page_req), .src_page(src_page),
        .src_valid(src_valid), .src_data(src_data), .src_err(src_err),
        .src_ready(src_ready), .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n),
        .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_done(tgt_done)
    );

    int vectors = 0;
    int miscompares = 0;
    int epoch = 0;
    int bad_idx = -1, stall_k = 0, stall_page = -1, err_page = -1;

    function automatic logic [7:0] img_byte(int p, int i);
        logic [7:0] b;
        if (p == 0 && i < ML) begin
            b = MK[(ML-1-i)*8 +: 8];
            if (i == bad_idx) b = b ^ 8'h01;
        end else begin
            b = 8'((p * 37 + i * 11 + 3) & 255);
        end
        return b;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // source model: state at posedge, outputs at negedge
    int s_ep = -1, cur_page = -1, remain = 0, bidx = 0, cyc = 0, preq = 0, seq_err = 0;
    always @(posedge clk) begin
        if (s_ep != epoch) begin
            s_ep = epoch; cur_page = -1; remain = 0; bidx = 0; preq = 0; seq_err = 0;
        end
        cyc++;
        if (src_page_req) begin
            if (int'(src_page) != preq) seq_err++;
            preq++;
            cur_page = int'(src_page);
            remain = PB;
            bidx = 0;
        end else if (src_valid && src_ready) begin
            remain--;
            bidx++;
        end
    end
    always @(negedge clk) begin
        src_valid <= (remain > 0) && (cur_page != stall_page) && ((cyc % (stall_k + 1)) == 0);
        src_data  <= img_byte(cur_page, bidx);
        src_err   <= (cur_page == err_page) && (remain > 0) && (bidx == 1);
    end

    // target model: capture on rising clock
    int t_ep = -1, nbit = 0, nrx = 0, pre_dmy = 0, post_dmy = 0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] rx [64];
    always @(posedge tgt_sck) begin
        if (t_ep != epoch) begin
            t_ep = epoch; nbit = 0; nrx = 0; pre_dmy = 0; post_dmy = 0;
        end
        if (!tgt_cs_n) begin
            shreg = {shreg[6:0], tgt_mosi};
            nbit++;
            if (nbit == 8) begin
                if (nrx < 64) rx[nrx] = shreg;
                nrx++;
                nbit = 0;
            end
        end else if (nrx == 0) begin
            pre_dmy++;
        end else begin
            post_dmy++;
        end
    end

    // pin timing monitor
    int m_ep = -1, hold_c = 0, hold_at = -1, wake_c = 0, wake_at = -1, lowlen = 0;
    int bad_low = 0, bad_cs = 0;
    logic cs_at = 1'b1, released = 1'b0, p_rst = 1'b0, p_cs = 1'b1, p_sck = 1'b1;
    always @(negedge clk) begin
        if (m_ep != epoch) begin
            m_ep = epoch; hold_c = 0; hold_at = -1; wake_c = 0; wake_at = -1;
            lowlen = 0; bad_low = 0; bad_cs = 0; cs_at = 1'b1; released = 1'b0;
        end
        if (!tgt_cs_n && !tgt_rst_n) hold_c++;
        if (tgt_rst_n && !p_rst) begin
            hold_at = hold_c; cs_at = tgt_cs_n; released = 1'b1; wake_c = 0;
        end else if (released && wake_at < 0) begin
            if (!tgt_sck) wake_at = wake_c; else wake_c++;
        end
        if (!tgt_sck) lowlen++;
        else begin
            if (!p_sck && lowlen != CLK_DIV / 2) bad_low++;
            lowlen = 0;
        end
        if (tgt_cs_n != p_cs && !tgt_sck) bad_cs++;
        p_rst = tgt_rst_n; p_cs = tgt_cs_n; p_sck = tgt_sck;
    end

    // watchdog
    int gcyc = 0;
    always @(posedge clk) begin
        gcyc++;
        if (gcyc > 150000) begin
            $display("FAIL R10 watchdog actual=%0d expected=%0d", gcyc, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors + 1, miscompares + 1);
            $finish;
        end
    end

    task automatic run_case(int bad, int dv, int sk, int sp, int ep, bit restart);
        int n, exp_res, exp_bytes, exp_post, exp_preq, mism;
        epoch++;
        bad_idx = bad; stall_k = sk; stall_page = sp; err_page = ep;
        tgt_done = dv[0];
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10 busy after start", int'(busy), 1);
        if (restart) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk("R10 completion", int'(done), 1);
        if (bad >= 0) exp_res = 2;
        else if (sp >= 0 || ep >= 0) exp_res = 1;
        else exp_res = dv ? 0 : 3;
        exp_bytes = (sp >= 0) ? sp * PB : (ep >= 0) ? ep * PB + 1 : NP * PB;
        exp_preq  = (sp >= 0) ? sp + 1 : (ep >= 0) ? ep + 1 : NP;
        exp_post  = (exp_res == 0) ? (TAILB + POSTB) * 8 : (exp_res == 3) ? TAILB * 8 : 0;
        repeat (20) @(negedge clk);
        chk("R6/R9 result code", int'(result), exp_res);
        chk("R10 done held", int'(done), 1);
        chk("R10 idle after finish", int'(busy), 0);
        chk("R5 bytes captured", nrx, exp_bytes);
        mism = 0;
        for (int k = 0; k < exp_bytes && k < nrx && k < 64; k++)
            if (rx[k] != img_byte(k / PB, k % PB)) mism++;
        chk("R1/R5 byte content msb first", mism, 0);
        chk("R5 page requests", preq, exp_preq);
        chk("R5 page index order", seq_err, 0);
        chk("R4 dummy clocks before image", pre_dmy, 8);
        chk("R7/R8 dummy clocks after image", post_dmy, exp_post);
        chk("R3 reset hold with chip selected", int'(hold_at >= RHOLD), 1);
        chk("R3 release while selected", int'(cs_at), 0);
        chk("R4 quiet wake window", int'(wake_at >= WAKE), 1);
        chk("R1 clock low phase length", bad_low, 0);
        chk("R1 select moves only with clock high", bad_cs, 0);
        chk("R9 chip deselected at end", int'(tgt_cs_n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset tgt_rst_n", int'(tgt_rst_n), 0);
        chk("R2 reset tgt_cs_n", int'(tgt_cs_n), 1);
        chk("R2 reset tgt_sck", int'(tgt_sck), 1);
        chk("R2 reset busy", int'(busy), 0);
        chk("R2 reset done", int'(done), 0);
        chk("R2 reset result", int'(result), 0);

        for (int b = -1; b < ML; b++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 3; s += 2)
                    run_case(b, d, s, -1, -1, 1'b0);

        run_case(-1, 1, 1, 1, -1, 1'b0);  // R9 timeout in page 1
        run_case(1, 1, 0, 2, -1, 1'b0);   // R9 timeout after bad marker
        run_case(-1, 1, 0, -1, 1, 1'b0);  // R9 source error
        run_case(0, 1, 0, -1, 2, 1'b0);   // R9 source error after bad marker
        run_case(-1, 1, 2, -1, -1, 1'b1); // R10 start while busy ignored

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule